// File: doc/BRIEF.md
# Sixteen-Pin GPIO Bank with Masked Writes and a Shared Interrupt

This block controls sixteen general-purpose pins from a simple word-addressed register bus. Software picks each pin's direction, drives output levels through a masked write, reads the synchronized pin levels, and controls interrupts. A single output write carries a per-pin mask in its upper half-word, so any subset of pins can be set or cleared atomically without a read-modify-write. The direction register is readable so that read-modify-write remains possible where software wants it.

The lower eight pins each raise their own interrupt line, which follows the synchronized pin level directly. The upper eight pins are each gated by an enable bit, and the gated results are ORed into one active-high shared request. A parameter places the enable for upper pin N either at bit N or at bit N-8 of the enable register. A control register holds a soft reset bit and a clock enable. After power-on the bank sits in soft reset with the clock off. Writing 3 and then 1 brings it up, and writing 2 parks it.

Top module: `gpio_bank`

## Requirements
- R1: After `rst` (synchronous, active high) the direction, output and interrupt-enable registers are 0, the control register reads 2 (soft reset on, clock off), `pad_oe`, `pad_out`, `irq_pin` and `irq_shared` are 0.
- R2: A write to offset 0x00 loads `bus_wdata[15:0]` into the direction register (1 = output). It appears on `pad_oe` after the write edge and reads back at 0x00 with bits 31:16 zero.
- R3: A write to offset 0x08 updates output latch bit i to `bus_wdata[i]` only where `bus_wdata[16+i]` is 1, and leaves the other bits unchanged. The latch drives `pad_out` and reads back at 0x08 in bits 15:0.
- R4: Offset 0x0C reads the pin levels in bits 15:0 (bits 31:16 zero). A change on `pad_in` becomes visible on the third rising edge after it: two synchronizer flops and one pin-state register.
- R5: `irq_pin[i]` for i = 0..7 equals the pin-state bit i and does not depend on the interrupt-enable register.
- R6: `irq_shared` is the OR over pins 8..15 of the pin-state bit ANDed with that pin's enable. With `SHARED_EN_LOW` = 0 the enable for pin N is enable-register bit N. An enable write takes effect on `irq_shared` one clock after the write edge.
- R7: Offset 0x14 is the control register: bit 0 is clock enable and bit 1 is soft reset. It reads back in bits 1:0.
- R8: While the soft reset bit is 1, including the write edge that sets it, the direction, output and interrupt-enable registers are 0 and writes to them are ignored.
- R9: While the clock enable is 0, the pin-state register, `irq_pin` and `irq_shared` hold their values regardless of `pad_in`.
- R10: Reads from any other offset return 0, and writes to them change no register.
- R11: With `SHARED_EN_LOW` = 1 the enable for upper pin N is enable-register bit N-8, and bits 15:8 have no effect on `irq_shared`.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Write strobe, one cycle per write |
| bus_addr | input | 5 | Byte offset of the register |
| bus_wdata | input | 32 | Write data |
| bus_rdata | output | 32 | Read data for `bus_addr`, combinational |
| pad_in | input | 16 | Pin levels from the pads, asynchronous |
| pad_oe | output | 16 | Per-pin output enable |
| pad_out | output | 16 | Per-pin output level |
| irq_pin | output | 8 | Individual requests for pins 0..7 |
| irq_shared | output | 1 | Enable-gated OR request for pins 8..15 |

## Verification
The bench writes masks that touch only some pins, including an all-zero mask. A design that ignored the mask would overwrite bits that were never selected. It probes pin-state at the second and third edges after an input change, which catches a synchronizer that is one flop too short or too long. It sets soft reset while the registers hold values and then writes to them during reset. A one-cycle-late clear, or a register that accepts writes during reset, would leave a nonzero `pad_oe`. Two instances with opposite enable placement receive the same enable patterns, and the interrupt levels are checked with the clock frozen. A design that used the wrong half of the enable register, or let `irq_shared` follow the pins while stopped, would raise the shared request at the wrong time.

// File: rtl/gpio_bank_pkg.sv
package gpio_bank_pkg;

    localparam int GPIO_PINS  = 16;
    localparam int GPIO_HALF  = GPIO_PINS / 2;
    localparam int BUS_DW     = 32;
    localparam int BUS_AW     = 5;

    localparam logic [BUS_AW-1:0] OFS_DIR  = 5'h00;
    localparam logic [BUS_AW-1:0] OFS_OUT  = 5'h08;
    localparam logic [BUS_AW-1:0] OFS_PIN  = 5'h0C;
    localparam logic [BUS_AW-1:0] OFS_IEN  = 5'h10;
    localparam logic [BUS_AW-1:0] OFS_CTL  = 5'h14;

    // control register: bit1 soft reset, bit0 clock enable
    typedef struct packed {
        logic soft_rst;
        logic clk_en;
    } bank_ctl_t;

    localparam bank_ctl_t CTL_POR = '{soft_rst: 1'b1, clk_en: 1'b0};

    // masked update: upper half-word selects pins, lower half-word gives values
    function automatic logic [GPIO_PINS-1:0] masked_merge(
        input logic [GPIO_PINS-1:0] cur,
        input logic [BUS_DW-1:0]    word
    );
        logic [GPIO_PINS-1:0] sel;
        sel = word[BUS_DW-1:GPIO_PINS];
        return (cur & ~sel) | (word[GPIO_PINS-1:0] & sel);
    endfunction

endpackage

// File: rtl/gpio_bank_sync.sv
module gpio_bank_sync #(
    parameter int WIDTH  = 16,
    parameter int STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic [WIDTH-1:0] d_async,
    output logic [WIDTH-1:0] q_sync
);
    logic [WIDTH-1:0] chain [STAGES];

    for (genvar s = 0; s < STAGES; s++) begin : g_stage
        always_ff @(posedge clk) begin
            if (rst)
                chain[s] <= '0;
            else if (s == 0)
                chain[s] <= d_async;
            else
                chain[s] <= chain[(s == 0) ? 0 : s-1];
        end
    end

    assign q_sync = chain[STAGES-1];
endmodule

// File: rtl/gpio_bank_regs.sv
module gpio_bank_regs
    import gpio_bank_pkg::*;
(
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 bus_wr,
    input  logic [BUS_AW-1:0]    bus_addr,
    input  logic [BUS_DW-1:0]    bus_wdata,
    input  logic [GPIO_PINS-1:0] pin_state,
    output logic [BUS_DW-1:0]    bus_rdata,
    output logic [GPIO_PINS-1:0] dir_q,
    output logic [GPIO_PINS-1:0] out_q,
    output logic [GPIO_PINS-1:0] ien_q,
    output bank_ctl_t            ctl_q
);
    logic wr_dir, wr_out, wr_ien, wr_ctl;
    logic hold_clear;
    bank_ctl_t ctl_wr_val;

    always_comb begin
        wr_dir     = bus_wr && (bus_addr == OFS_DIR);
        wr_out     = bus_wr && (bus_addr == OFS_OUT);
        wr_ien     = bus_wr && (bus_addr == OFS_IEN);
        wr_ctl     = bus_wr && (bus_addr == OFS_CTL);
        ctl_wr_val = bank_ctl_t'(bus_wdata[1:0]);
        // clear on the same edge that sets soft reset
        hold_clear = ctl_q.soft_rst || (wr_ctl && ctl_wr_val.soft_rst);
    end

    always_ff @(posedge clk) begin
        if (rst)
            ctl_q <= CTL_POR;
        else if (wr_ctl)
            ctl_q <= ctl_wr_val;
    end

    always_ff @(posedge clk) begin
        if (rst || hold_clear) begin
            dir_q <= '0;
            out_q <= '0;
            ien_q <= '0;
        end else begin
            if (wr_dir)
                dir_q <= bus_wdata[GPIO_PINS-1:0];
            if (wr_out)
                out_q <= masked_merge(out_q, bus_wdata);
            if (wr_ien)
                ien_q <= bus_wdata[GPIO_PINS-1:0];
        end
    end

    always_comb begin
        unique case (bus_addr)
            OFS_DIR: bus_rdata = {{(BUS_DW-GPIO_PINS){1'b0}}, dir_q};
            OFS_OUT: bus_rdata = {{(BUS_DW-GPIO_PINS){1'b0}}, out_q};
            OFS_PIN: bus_rdata = {{(BUS_DW-GPIO_PINS){1'b0}}, pin_state};
            OFS_IEN: bus_rdata = {{(BUS_DW-GPIO_PINS){1'b0}}, ien_q};
            OFS_CTL: bus_rdata = {{(BUS_DW-2){1'b0}}, ctl_q};
            default: bus_rdata = '0;
        endcase
    end
endmodule

// File: rtl/gpio_bank_irq.sv
module gpio_bank_irq
    import gpio_bank_pkg::*;
#(
    parameter bit SHARED_EN_LOW = 1'b0
) (
    input  logic                 clk,
    input  logic                 rst,
    input  logic                 clk_en,
    input  logic [GPIO_PINS-1:0] sync_in,
    input  logic [GPIO_PINS-1:0] ien,
    output logic [GPIO_PINS-1:0] pin_state,
    output logic [GPIO_HALF-1:0] irq_pin,
    output logic                 irq_shared
);
    logic [GPIO_HALF-1:0] shared_en;
    logic                 shared_next;

    always_comb begin
        shared_en   = SHARED_EN_LOW ? ien[GPIO_HALF-1:0] : ien[GPIO_PINS-1:GPIO_HALF];
        shared_next = |(sync_in[GPIO_PINS-1:GPIO_HALF] & shared_en);
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            pin_state  <= '0;
            irq_shared <= 1'b0;
        end else if (clk_en) begin
            pin_state  <= sync_in;
            irq_shared <= shared_next;
        end
    end

    assign irq_pin = pin_state[GPIO_HALF-1:0];
endmodule

// File: rtl/gpio_bank.sv
module gpio_bank
    import gpio_bank_pkg::*;
#(
    parameter bit SHARED_EN_LOW = 1'b0,
    parameter int SYNC_STAGES   = 2
) (
    input  logic        clk,
    input  logic        rst,
    input  logic        bus_wr,
    input  logic [4:0]  bus_addr,
    input  logic [31:0] bus_wdata,
    output logic [31:0] bus_rdata,
    input  logic [15:0] pad_in,
    output logic [15:0] pad_oe,
    output logic [15:0] pad_out,
    output logic [7:0]  irq_pin,
    output logic        irq_shared
);
    logic [GPIO_PINS-1:0] sync_in;
    logic [GPIO_PINS-1:0] pin_state;
    logic [GPIO_PINS-1:0] dir_q, out_q, ien_q;
    bank_ctl_t            ctl_q;
    logic                 blk_rst, clk_en;

    gpio_bank_sync #(.WIDTH(GPIO_PINS), .STAGES(SYNC_STAGES)) u_sync (
        .clk     (clk),
        .rst     (rst),
        .d_async (pad_in),
        .q_sync  (sync_in)
    );

    gpio_bank_regs u_regs (
        .clk       (clk),
        .rst       (rst),
        .bus_wr    (bus_wr),
        .bus_addr  (bus_addr),
        .bus_wdata (bus_wdata),
        .pin_state (pin_state),
        .bus_rdata (bus_rdata),
        .dir_q     (dir_q),
        .out_q     (out_q),
        .ien_q     (ien_q),
        .ctl_q     (ctl_q)
    );

    assign blk_rst = ctl_q.soft_rst;
    assign clk_en  = ctl_q.clk_en;

    gpio_bank_irq #(.SHARED_EN_LOW(SHARED_EN_LOW)) u_irq (
        .clk        (clk),
        .rst        (rst),
        .clk_en     (clk_en),
        .sync_in    (sync_in),
        .ien        (ien_q),
        .pin_state  (pin_state),
        .irq_pin    (irq_pin),
        .irq_shared (irq_shared)
    );

    assign pad_oe  = dir_q;
    assign pad_out = out_q;
endmodule

// File: rtl/gpio_bank_chk.sv
module gpio_bank_chk #(
    parameter bit SHARED_EN_LOW = 1'b0
) (
    input logic        clk,
    input logic        rst,
    input logic        bus_wr,
    input logic [4:0]  bus_addr,
    input logic [31:0] bus_wdata,
    input logic [31:0] bus_rdata,
    input logic [15:0] pad_oe,
    input logic [15:0] pad_out,
    input logic [7:0]  irq_pin,
    input logic        irq_shared,
    input logic        blk_rst,
    input logic        clk_en,
    input logic [15:0] ien
);
    logic [7:0] en_eff;
    logic       mapped;
    assign en_eff = SHARED_EN_LOW ? ien[7:0] : ien[15:8];
    assign mapped = (bus_addr == 5'h00) || (bus_addr == 5'h08) || (bus_addr == 5'h0C) ||
                    (bus_addr == 5'h10) || (bus_addr == 5'h14);

    // R8
    a_r8_held_in_reset: assert property (@(posedge clk) disable iff (rst)
        blk_rst |-> (pad_oe == 16'h0 && pad_out == 16'h0 && ien == 16'h0));

    // R2
    a_r2_dir_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 5'h00 && !blk_rst) |=> pad_oe == $past(bus_wdata[15:0]));

    // R3
    a_r3_masked_write: assert property (@(posedge clk) disable iff (rst)
        (bus_wr && bus_addr == 5'h08 && !blk_rst) |=>
        pad_out == (($past(pad_out) & ~$past(bus_wdata[31:16])) |
                    ($past(bus_wdata[15:0]) & $past(bus_wdata[31:16]))));

    // R9
    a_r9_frozen_irq: assert property (@(posedge clk) disable iff (rst)
        !clk_en |=> ($stable(irq_pin) && $stable(irq_shared)));

    // R6
    a_r6_shared_gated: assert property (@(posedge clk) disable iff (rst)
        (clk_en && en_eff == 8'h0) |=> !irq_shared);

    // R10
    a_r10_unmapped_zero: assert property (@(posedge clk) disable iff (rst)
        !mapped |-> bus_rdata == 32'h0);
endmodule

bind gpio_bank gpio_bank_chk #(.SHARED_EN_LOW(SHARED_EN_LOW)) u_chk (
    .clk        (clk),
    .rst        (rst),
    .bus_wr     (bus_wr),
    .bus_addr   (bus_addr),
    .bus_wdata  (bus_wdata),
    .bus_rdata  (bus_rdata),
    .pad_oe     (pad_oe),
    .pad_out    (pad_out),
    .irq_pin    (irq_pin),
    .irq_shared (irq_shared),
    .blk_rst    (blk_rst),
    .clk_en     (clk_en),
    .ien        (ien_q)
);

// File: tb/sim_gpio_bank.sv
module sim_gpio_bank;
    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        bus_wr = 1'b0;
    logic [4:0]  bus_addr = 5'h0;
    logic [31:0] bus_wdata = 32'h0;
    logic [15:0] pad_in = 16'h0;

    logic [31:0] rdata0, rdata1;
    logic [15:0] oe0, out0, oe1, out1;
    logic [7:0]  irqp0, irqp1;
    logic        irqs0, irqs1;

    int n_run = 0;
    int n_fail = 0;

    always #4 clk = ~clk;

    gpio_bank #(.SHARED_EN_LOW(1'b0)) u0 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata0), .pad_in(pad_in),
        .pad_oe(oe0), .pad_out(out0), .irq_pin(irqp0), .irq_shared(irqs0)
    );

    gpio_bank #(.SHARED_EN_LOW(1'b1)) u1 (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(rdata1), .pad_in(pad_in),
        .pad_oe(oe1), .pad_out(out1), .irq_pin(irqp1), .irq_shared(irqs1)
    );

    task automatic chk(input string tag, input logic [31:0] act, input logic [31:0] exp);
        n_run++;
        if (act !== exp) begin
            n_fail++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [4:0] a, input logic [31:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic rd(input logic [4:0] a, output logic [31:0] v);
        bus_addr = a;
        #1;
        v = rdata0;
    endtask

    task automatic set_pins(input logic [15:0] v);
        @(negedge clk);
        pad_in = v;
        repeat (3) @(negedge clk);
    endtask

    task automatic t_reset();
        logic [31:0] v;
        rst = 1'b1;
        repeat (3) @(negedge clk);
        rst = 1'b0;
        @(negedge clk);
        rd(5'h14, v); chk("R1 ctl after reset", v, 32'h2);
        rd(5'h00, v); chk("R1 dir after reset", v, 32'h0);
        chk("R1 pad_oe/pad_out", {oe0, out0}, 32'h0);
        chk("R1 irqs", {23'h0, irqs0, irqp0}, 32'h0);
    endtask

    task automatic t_bringup();
        logic [31:0] v;
        wr(5'h14, 32'h3);
        rd(5'h14, v); chk("R7 ctl=3", v, 32'h3);
        wr(5'h14, 32'h1);
        rd(5'h14, v); chk("R7 ctl=1", v, 32'h1);
    endtask

    task automatic t_direction();
        logic [31:0] v;
        wr(5'h00, 32'hFFFF_A55A);
        chk("R2 pad_oe", {16'h0, oe0}, 32'hA55A);
        rd(5'h00, v); chk("R2 dir readback", v, 32'h0000_A55A);
    endtask

    task automatic t_masked();
        logic [31:0] v;
        wr(5'h08, 32'hFFFF_1234);
        chk("R3 full mask", {16'h0, out0}, 32'h1234);
        wr(5'h08, 32'h00F0_FFFF);
        chk("R3 partial mask set", {16'h0, out0}, 32'h12F4);
        wr(5'h08, 32'h0000_FFFF);
        chk("R3 empty mask", {16'h0, out0}, 32'h12F4);
        wr(5'h08, 32'h0004_0000);
        rd(5'h08, v); chk("R3 clear one pin readback", v, 32'h12F0);
    endtask

    task automatic t_pinstate();
        @(negedge clk);
        pad_in = 16'h5A3C;
        bus_addr = 5'h0C;
        repeat (2) @(negedge clk);
        chk("R4 not visible after two edges", rdata0, 32'h0);
        @(negedge clk);
        chk("R4 visible after three edges", rdata0, 32'h0000_5A3C);
    endtask

    task automatic t_direct_irq();
        wr(5'h10, 32'h0);
        set_pins(16'h00A5);
        chk("R5 irq_pin with enables clear", {24'h0, irqp0}, 32'hA5);
        wr(5'h10, 32'hFFFF);
        @(negedge clk);
        chk("R5 irq_pin with enables set", {24'h0, irqp0}, 32'hA5);
    endtask

    task automatic t_shared_irq();
        wr(5'h10, 32'h0);
        set_pins(16'hFF00);
        chk("R6 shared off when no enable", {31'h0, irqs0}, 32'h0);
        wr(5'h10, 32'h8000);
        @(negedge clk);
        chk("R6 bit15 enables pin15", {31'h0, irqs0}, 32'h1);
        chk("R11 bit15 ignored in low mode", {31'h0, irqs1}, 32'h0);
        wr(5'h10, 32'h0080);
        @(negedge clk);
        chk("R6 bit7 not a shared enable", {31'h0, irqs0}, 32'h0);
        chk("R11 bit7 enables pin15", {31'h0, irqs1}, 32'h1);
        wr(5'h10, 32'h0202);
        set_pins(16'h0200);
        chk("R6 pin9 alone via bit9", {31'h0, irqs0}, 32'h1);
        chk("R11 pin9 alone via bit1", {31'h0, irqs1}, 32'h1);
        set_pins(16'h0400);
        chk("R6 unenabled pin10", {31'h0, irqs0}, 32'h0);
    endtask

    task automatic t_soft_reset();
        logic [31:0] v;
        wr(5'h00, 32'hFFFF);
        wr(5'h08, 32'hFFFF_FFFF);
        wr(5'h14, 32'h3);
        chk("R8 dir cleared on reset edge", {16'h0, oe0}, 32'h0);
        chk("R8 out cleared", {16'h0, out0}, 32'h0);
        wr(5'h00, 32'h00FF);
        wr(5'h08, 32'hFFFF_FFFF);
        wr(5'h10, 32'hFFFF);
        chk("R8 writes ignored dir/out", {oe0, out0}, 32'h0);
        rd(5'h10, v); chk("R8 ien write ignored", v, 32'h0);
        wr(5'h14, 32'h1);
        wr(5'h00, 32'h0F0F);
        chk("R8 dir writable after release", {16'h0, oe0}, 32'h0F0F);
    endtask

    task automatic t_freeze();
        logic [31:0] v;
        wr(5'h10, 32'h0101);
        set_pins(16'h0101);
        chk("R9 setup irqs", {23'h0, irqs0, irqp0}, 32'h101);
        wr(5'h14, 32'h0);
        rd(5'h14, v); chk("R7 ctl=0", v, 32'h0);
        set_pins(16'h0000);
        repeat (2) @(negedge clk);
        chk("R9 irqs held with clock off", {23'h0, irqs0, irqp0}, 32'h101);
        rd(5'h0C, v); chk("R9 pin state held", v, 32'h0101);
        wr(5'h14, 32'h1);
        repeat (2) @(negedge clk);
        chk("R9 irqs follow after restart", {23'h0, irqs0, irqp0}, 32'h0);
    endtask

    task automatic t_unmapped();
        logic [31:0] v;
        wr(5'h00, 32'h1234);
        wr(5'h04, 32'hFFFF_FFFF);
        wr(5'h18, 32'hFFFF_FFFF);
        rd(5'h04, v); chk("R10 read 0x04", v, 32'h0);
        rd(5'h1C, v); chk("R10 read 0x1C", v, 32'h0);
        rd(5'h00, v); chk("R10 dir untouched", v, 32'h1234);
        rd(5'h14, v); chk("R10 ctl untouched", v, 32'h1);
    endtask

    initial begin
        repeat (20000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog expired");
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end

    initial begin
        t_reset();
        t_bringup();
        t_direction();
        t_masked();
        t_pinstate();
        t_direct_irq();
        t_shared_irq();
        t_soft_reset();
        t_freeze();
        t_unmapped();
        repeat (2) @(negedge clk);
        $display("[TB] %0d tests run, %0d failed", n_run, n_fail);
        $finish;
    end
endmodule